// File: doc/BRIEF.md
# Receive Holding Queue with Break Insertion

This block is a small byte queue that sits between a serial receiver's shift stage and the host's read port. The receive side offers bytes with a valid/ready handshake. It takes them only while the receiver is enabled and the queue has room. A detected line break is stored as a zero byte, whatever the queue holds. The host reads the oldest byte from a combinational data output and strobes a read to remove it.

The queue reports two status flags: data available and queue full. It also keeps a sticky break-change flag that stays set until a command input clears it. A flush input empties the queue when the receiver is reset. If a break arrives while the queue is full, its zero byte replaces the newest entry, so the break is never lost. A read of an empty queue returns zero and changes nothing.

Top module: `rxq_hold`

## Requirements
- R1: After a synchronous reset the queue is empty: `rx_rdy`, `rx_full` and `brk_pend` are 0 and `rd_data` is 0x00.
- R2: `in_ready` equals `rx_en` and not `rx_full` and not `brk_det`. A byte is stored only when `in_valid` and `in_ready` are both high. An offered byte without `in_ready` has no effect.
- R3: Bytes leave in arrival order. While the queue is not empty, `rd_data` shows the oldest byte. A `rd_req` high at a clock edge removes that byte.
- R4: `rx_rdy` is 1 exactly when the queue holds at least one byte. `rx_full` is 1 exactly when it holds DEPTH bytes (4 by default).
- R5: When the queue is empty, `rd_data` is 0x00 and a `rd_req` changes no state.
- R6: `brk_det` high at a clock edge stores a 0x00 byte even when `rx_en` is low, and sets `brk_pend`.
- R7: A break arriving when the queue is full and no read happens in that cycle overwrites the newest entry with 0x00. The count stays at DEPTH and the older entries are kept.
- R8: When a read and a store happen in the same cycle, the read is applied first. A full queue then takes the new byte as a normal append and stays full.
- R9: `flush` empties the queue and clears `rx_rdy` and `rx_full`. It overrides a store or read in the same cycle and leaves `brk_pend` unchanged.
- R10: `brk_pend` stays set until `brk_clr` is high at an edge with no `brk_det`. If both are high in the same cycle, the flag is set. Queue contents do not affect it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Receiver enabled |
| flush | input | 1 | Receiver reset: empty the queue |
| in_valid | input | 1 | Receive byte offered |
| in_data | input | DW | Offered receive byte |
| in_ready | output | 1 | Queue accepts the offered byte |
| brk_det | input | 1 | Break detected this cycle |
| brk_clr | input | 1 | Clear the break-change flag |
| rd_req | input | 1 | Host read strobe (pops the oldest byte) |
| rd_data | output | DW | Oldest byte, 0x00 when empty |
| rx_rdy | output | 1 | At least one byte held |
| rx_full | output | 1 | DEPTH bytes held |
| brk_pend | output | 1 | Sticky break-change flag |

## Verification
The bench fills the queue and then sends a break. A design that dropped the zero or shifted out the oldest byte would read back the wrong sequence. It sends a read and a break together on a full queue; a design that resolved the store before the read would overwrite data and lose a byte. It reads an empty queue and flushes while a store and a read are pending. Either mistake would show up as a stray byte or a moved head. It also sets and clears the break flag in the same cycle, where a reversed priority would lose the event.

// File: rtl/rxq_pkg.sv
`timescale 1ns/1ps
package rxq_pkg;

    // Kind of write the control logic issues to the storage this cycle
    typedef enum logic [1:0] {
        WOP_NONE    = 2'd0,
        WOP_APPEND  = 2'd1,
        WOP_REPLACE = 2'd2
    } wop_e;

    // Index width for a ring of the given depth (at least one bit)
    function automatic int idx_width(input int depth);
        return (depth > 1) ? $clog2(depth) : 1;
    endfunction

    // Position 'off' slots after 'base' in a ring of 'depth' slots
    function automatic logic [31:0] ring_idx(input logic [31:0] base,
                                             input logic [31:0] off,
                                             input logic [31:0] depth);
        return (base + off) % depth;
    endfunction

endpackage

// File: rtl/rxq_src.sv
`timescale 1ns/1ps
module rxq_src #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rx_en,
    input  logic          rx_full,
    input  logic          in_valid,
    input  logic [DW-1:0] in_data,
    input  logic          brk_det,
    input  logic          brk_clr,
    output logic          in_ready,
    output logic          push_vld,
    output logic [DW-1:0] push_byte,
    output logic          brk_pend
);

    // A break owns the write slot of its cycle, so the line byte waits
    assign in_ready  = rx_en && !rx_full && !brk_det;
    assign push_vld  = brk_det || (in_valid && in_ready);
    assign push_byte = brk_det ? '0 : in_data;

    // Sticky break-change flag: set has priority over clear
    always_ff @(posedge clk) begin
        if (rst) begin
            brk_pend <= 1'b0;
        end else if (brk_det) begin
            brk_pend <= 1'b1;
        end else if (brk_clr) begin
            brk_pend <= 1'b0;
        end
    end

endmodule

// File: rtl/rxq_ctrl.sv
`timescale 1ns/1ps
module rxq_ctrl
    import rxq_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int IW    = 2,
    parameter int CW    = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          rd_req,
    input  logic          push_vld,
    output logic [IW-1:0] head,
    output logic [CW-1:0] count,
    output wop_e          wop,
    output logic [IW-1:0] widx
);

    logic          pop;
    logic [CW-1:0] cnt_mid;
    logic [CW-1:0] cnt_nxt;
    logic [IW-1:0] head_nxt;

    always_comb begin
        pop      = rd_req && (count != '0);
        cnt_mid  = count - CW'(pop);
        cnt_nxt  = cnt_mid;
        head_nxt = pop ? IW'(ring_idx(32'(head), 32'd1, 32'(DEPTH))) : head;
        wop      = WOP_NONE;
        widx     = '0;
        if (flush) begin
            cnt_nxt  = '0;
            head_nxt = '0;
        end else if (push_vld) begin
            if (cnt_mid == CW'(DEPTH)) begin
                // Still full after the pop stage: overwrite the newest slot
                wop  = WOP_REPLACE;
                widx = IW'(ring_idx(32'(head), 32'(DEPTH - 1), 32'(DEPTH)));
            end else begin
                // Tail slot, correct whether or not a pop happened
                wop     = WOP_APPEND;
                widx    = IW'(ring_idx(32'(head), 32'(count), 32'(DEPTH)));
                cnt_nxt = cnt_mid + CW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            head  <= '0;
            count <= '0;
        end else begin
            head  <= head_nxt;
            count <= cnt_nxt;
        end
    end

endmodule

// File: rtl/rxq_store.sv
`timescale 1ns/1ps
module rxq_store #(
    parameter int DEPTH = 4,
    parameter int DW    = 8,
    parameter int IW    = 2
) (
    input  logic          clk,
    input  logic          we,
    input  logic [IW-1:0] widx,
    input  logic [DW-1:0] wdata,
    input  logic [IW-1:0] ridx,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] slot [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (we && (widx == IW'(i))) begin
                slot[i] <= wdata;
            end
        end
    end

    assign rdata = slot[ridx];

endmodule

// File: rtl/rxq_hold.sv
`timescale 1ns/1ps
module rxq_hold
    import rxq_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int DW    = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rx_en,
    input  logic          flush,
    input  logic          in_valid,
    input  logic [DW-1:0] in_data,
    output logic          in_ready,
    input  logic          brk_det,
    input  logic          brk_clr,
    input  logic          rd_req,
    output logic [DW-1:0] rd_data,
    output logic          rx_rdy,
    output logic          rx_full,
    output logic          brk_pend
);

    localparam int IW = idx_width(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic          push_vld;
    logic [DW-1:0] push_byte;
    logic [IW-1:0] head;
    logic [CW-1:0] count;
    wop_e          wop;
    logic [IW-1:0] widx;
    logic [DW-1:0] raw_data;

    assign rx_rdy  = (count != '0);
    assign rx_full = (count == CW'(DEPTH));

    rxq_src #(.DW(DW)) u_src (
        .clk       (clk),
        .rst       (rst),
        .rx_en     (rx_en),
        .rx_full   (rx_full),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .brk_det   (brk_det),
        .brk_clr   (brk_clr),
        .in_ready  (in_ready),
        .push_vld  (push_vld),
        .push_byte (push_byte),
        .brk_pend  (brk_pend)
    );

    rxq_ctrl #(.DEPTH(DEPTH), .IW(IW), .CW(CW)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .flush    (flush),
        .rd_req   (rd_req),
        .push_vld (push_vld),
        .head     (head),
        .count    (count),
        .wop      (wop),
        .widx     (widx)
    );

    rxq_store #(.DEPTH(DEPTH), .DW(DW), .IW(IW)) u_store (
        .clk   (clk),
        .we    (wop != WOP_NONE),
        .widx  (widx),
        .wdata (push_byte),
        .ridx  (head),
        .rdata (raw_data)
    );

    // Empty queue reads as zero; slots themselves carry no reset
    assign rd_data = rx_rdy ? raw_data : '0;

endmodule

// File: rtl/rxq_hold_chk.sv
`timescale 1ns/1ps
module rxq_hold_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          flush,
    input logic          rd_req,
    input logic          brk_det,
    input logic          brk_clr,
    input logic          in_valid,
    input logic          in_ready,
    input logic          rx_rdy,
    input logic          rx_full,
    input logic          brk_pend,
    input logic [DW-1:0] rd_data
);

    // R4
    full_has_rdy_chk: assert property (@(posedge clk) disable iff (rst)
        rx_full |-> rx_rdy);

    // R2
    full_blocks_ready_chk: assert property (@(posedge clk) disable iff (rst)
        rx_full |-> !in_ready);

    // R5
    empty_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !rx_rdy |-> (rd_data == '0));

    // R5
    empty_read_inert_chk: assert property (@(posedge clk) disable iff (rst)
        (!rx_rdy && !brk_det && !(in_valid && in_ready)) |=> !rx_rdy);

    // R9
    flush_empties_chk: assert property (@(posedge clk) disable iff (rst)
        flush |=> (!rx_rdy && !rx_full));

    // R6
    brk_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
        brk_det |=> brk_pend);

    // R6
    brk_stores_byte_chk: assert property (@(posedge clk) disable iff (rst)
        (brk_det && !flush) |=> rx_rdy);

    // R7
    full_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_full && !rd_req && !flush) |=> rx_full);

    // R8
    pop_then_push_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_full && rd_req && brk_det && !flush) |=> rx_full);

    // R10
    flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (brk_pend && !brk_clr) |=> brk_pend);

    // R10
    flag_no_spurious_chk: assert property (@(posedge clk) disable iff (rst)
        (!brk_pend && !brk_det) |=> !brk_pend);

endmodule

bind rxq_hold rxq_hold_chk #(.DW(DW)) u_chk (.*);

// File: tb/rxq_hold_bench.sv
`timescale 1ns/1ps
module rxq_hold_bench;

    localparam int DEPTH = 4;
    localparam int DW    = 8;

    logic          clk = 1'b0;
    logic          rst;
    logic          rx_en;
    logic          flush;
    logic          in_valid;
    logic [DW-1:0] in_data;
    logic          in_ready;
    logic          brk_det;
    logic          brk_clr;
    logic          rd_req;
    logic [DW-1:0] rd_data;
    logic          rx_rdy;
    logic          rx_full;
    logic          brk_pend;

    always #2.5 clk = ~clk;

    rxq_hold #(.DEPTH(DEPTH), .DW(DW)) u_rxq_hold (
        .clk      (clk),
        .rst      (rst),
        .rx_en    (rx_en),
        .flush    (flush),
        .in_valid (in_valid),
        .in_data  (in_data),
        .in_ready (in_ready),
        .brk_det  (brk_det),
        .brk_clr  (brk_clr),
        .rd_req   (rd_req),
        .rd_data  (rd_data),
        .rx_rdy   (rx_rdy),
        .rx_full  (rx_full),
        .brk_pend (brk_pend)
    );

    int  errs   = 0;
    int  checks = 0;
    bit  done   = 0;
    int  mq[$];
    bit  m_pend;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Compare every output against the behavioural queue model
    task automatic compare();
        int exp_rd;
        int exp_ready;
        exp_rd    = (mq.size() > 0) ? mq[0] : 0;
        exp_ready = (rx_en && mq.size() < DEPTH && !brk_det) ? 1 : 0;
        chk("R4 rx_rdy", int'(rx_rdy), (mq.size() > 0) ? 1 : 0);
        chk("R4 rx_full", int'(rx_full), (mq.size() == DEPTH) ? 1 : 0);
        chk("R2 in_ready", int'(in_ready), exp_ready);
        chk("R3 rd_data", int'(rd_data), exp_rd);
        chk("R10 brk_pend", int'(brk_pend), int'(m_pend));
    endtask

    task automatic model_update(input bit en, input bit v, input int d, input bit rd,
                                input bit bk, input bit bc, input bit fl);
        bit acc;
        acc = v && en && (mq.size() < DEPTH) && !bk;
        if (bk) m_pend = 1;
        else if (bc) m_pend = 0;
        if (fl) begin
            mq.delete();
        end else begin
            if (rd && mq.size() > 0) void'(mq.pop_front());
            if (bk) begin
                if (mq.size() == DEPTH) mq[DEPTH-1] = 0;
                else mq.push_back(0);
            end else if (acc) begin
                mq.push_back(d);
            end
        end
    endtask

    task automatic step(input bit en, input bit v, input int d, input bit rd,
                        input bit bk, input bit bc, input bit fl);
        @(negedge clk);
        rx_en = en; in_valid = v; in_data = DW'(d); rd_req = rd;
        brk_det = bk; brk_clr = bc; flush = fl;
        #1 compare();
        @(posedge clk);
        model_update(en, v, d, rd, bk, bc, fl);
        #1;
    endtask

    // Watchdog
    initial begin
        #750000;
        if (!done) begin
            errs++;
            checks++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        rst = 1; rx_en = 0; flush = 0; in_valid = 0; in_data = '0;
        brk_det = 0; brk_clr = 0; rd_req = 0;
        mq.delete(); m_pend = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        #1;
        // R1 reset state
        chk("R1 rx_rdy after reset", int'(rx_rdy), 0);
        chk("R1 rx_full after reset", int'(rx_full), 0);
        chk("R1 brk_pend after reset", int'(brk_pend), 0);
        chk("R1 rd_data after reset", int'(rd_data), 0);

        // R2 disabled receiver ignores offered byte
        step(0, 1, 8'h11, 0, 0, 0, 0);
        chk("R2 disabled receiver stores nothing", int'(rx_rdy), 0);

        // Fill to depth
        for (int i = 0; i < DEPTH; i++) step(1, 1, 8'hA1 + i, 0, 0, 0, 0);
        chk("R4 full at depth", int'(rx_full), 1);
        step(1, 1, 8'hEE, 0, 0, 0, 0);
        chk("R2 byte offered while full dropped", int'(rd_data), 8'hA1);

        // R3 pop order
        step(1, 0, 0, 1, 0, 0, 0);
        chk("R3 next oldest after pop", int'(rd_data), 8'hA2);
        chk("R4 full clears after pop", int'(rx_full), 0);

        // R7 break overwrites newest when full
        step(1, 1, 8'hA5, 0, 0, 0, 0);
        step(1, 0, 0, 0, 1, 0, 0);
        chk("R7 still full after break", int'(rx_full), 1);
        chk("R6 break sets flag", int'(brk_pend), 1);
        begin
            int exp_seq[4] = '{8'hA2, 8'hA3, 8'hA4, 8'h00};
            for (int k = 0; k < 4; k++) begin
                chk("R7 order after overwrite", int'(rd_data), exp_seq[k]);
                step(1, 0, 0, 1, 0, 0, 0);
            end
        end

        // R5 read of empty queue
        step(1, 0, 0, 1, 0, 0, 0);
        chk("R5 empty read keeps empty", int'(rx_rdy), 0);
        chk("R5 empty read data zero", int'(rd_data), 0);

        // R6 break stored with receiver disabled
        step(0, 0, 0, 0, 1, 0, 0);
        chk("R6 break stored when disabled", int'(rx_rdy), 1);
        chk("R6 break byte is zero", int'(rd_data), 0);

        // R10 clear, then simultaneous set and clear
        step(1, 0, 0, 0, 0, 1, 0);
        chk("R10 clear drops flag", int'(brk_pend), 0);
        chk("R10 clear leaves queue", int'(rx_rdy), 1);
        step(1, 0, 0, 0, 1, 1, 0);
        chk("R10 set wins over clear", int'(brk_pend), 1);

        // R9 flush overrides store and read
        step(1, 1, 8'h55, 1, 0, 0, 1);
        chk("R9 flush empties", int'(rx_rdy), 0);
        chk("R9 flush keeps break flag", int'(brk_pend), 1);

        // R8 read and break together on a full queue
        for (int i = 0; i < DEPTH; i++) step(1, 1, 8'hB0 + i, 0, 0, 0, 0);
        step(1, 0, 0, 1, 1, 0, 0);
        chk("R8 full after pop then push", int'(rx_full), 1);
        chk("R8 oldest popped first", int'(rd_data), 8'hB1);
        for (int k = 0; k < DEPTH - 1; k++) step(1, 0, 0, 1, 0, 0, 0);
        chk("R8 appended zero kept at tail", int'(rd_data), 0);
        chk("R8 one byte left", int'(rx_full), 0);

        // Mixed traffic
        for (int n = 0; n < 4000; n++) begin
            step(($urandom % 8) != 0, $urandom % 2, int'($urandom % 256),
                 ($urandom % 3) == 0, ($urandom % 16) == 0,
                 ($urandom % 8) == 0, ($urandom % 40) == 0);
        end

        step(1, 0, 0, 0, 0, 0, 1);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule